// File: doc/BRIEF.md
# Data-Break Disk Transfer Sequencer

This block moves words between main memory and a fixed-head disk on a machine with 12-bit words. It does so one word at a time, taking memory cycles from the processor for each word. The processor sets it up with I/O transfer instructions. One instruction loads the memory field of the target buffer. Another loads the upper six bits of the 18-bit disk address. A start instruction supplies the lower twelve disk-address bits and chooses the direction.

The engine has no counter registers of its own for the transfer length or the buffer pointer. Both live in two fixed words of memory field 0. For every word the engine reads the negative word count, increments it and writes it back. It then reads the buffer pointer, increments it and writes it back. Last, it moves one data word between memory and a ready/valid disk word port.

When the incremented count reaches zero, the engine raises a done flag. Software can poll that flag with a skip instruction, or take an interrupt when interrupts are enabled.

Top module: `dbk_disk_dma`

## Requirements
- R1: After reset the done flag, interrupt and skip outputs are low, the interrupt enable is clear, and no memory request, disk-port ready or disk-port valid is asserted.
- R2: An instruction is decoded when iot_insn[11:9] is octal 6. Its device field is bits [8:3] and its function is bits [2:0]. It takes effect once, on the first cycle that iot_phase equals 1 while iot_valid is high. The codes are:
  - octal 6603: start a disk-to-memory transfer.
  - octal 6605: start a memory-to-disk transfer.
  - octal 6615: load the memory field from data bits [5:3].
  - octal 6643: load disk address bits [17:12] from data bits [5:0].
  - octal 6611: load the interrupt enable from data bit 0.
  - octal 6601: the skip test.
- R3: Each word takes five memory accesses in this order, and all of them use field 0 for the two fixed words:
  - read octal 7750, then write it back;
  - read octal 7751, then write it back;
  - the data access.
- R4: The word at octal 7750 holds the negative of the word count. It is incremented once per word, and the transfer ends after the word in which it becomes zero. A value of -N moves exactly N words and leaves 0 in that location.
- R5: The word at octal 7751 holds one less than the first buffer address. It is incremented before each data access. The data address is {field, pointer}, and the pointer wraps from 7777 to 0000 without changing the field.
- R6: The 18-bit disk address shown on dsk_addr increments by one after each word and wraps from 777777 to 000000.
- R7: In a disk-to-memory transfer the engine raises dsk_in_ready. The word present when dsk_in_valid is also high is written to the data address.
- R8: In a memory-to-disk transfer the data word read from memory is driven on dsk_out_data with dsk_out_valid. Both the data and the disk address stay unchanged until dsk_out_ready is seen.
- R9: A start clears the done flag. The flag stays low while the transfer runs and is set when the last word finishes. iot_skip is high while the skip test instruction is presented and the flag is set.
- R10: irq is high exactly while both the done flag and the interrupt enable are set.
- R11: While a transfer is running, start, field-load and extension-load instructions are ignored.
- R12: A count word of 0 at the start moves 4096 words.
- R13: A memory read or write request, together with its address and write data, is held until mem_done is seen for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iot_valid | input | 1 | An I/O instruction is being presented |
| iot_phase | input | 2 | Processor phase 0 to 3 of the instruction |
| iot_insn | input | 12 | Instruction word |
| iot_wdata | input | 12 | Accumulator data supplied with the instruction |
| iot_skip | output | 1 | Skip request for the skip test instruction |
| irq | output | 1 | Interrupt request |
| xfer_done | output | 1 | Done flag |
| mem_rd_req | output | 1 | Memory read request |
| mem_wr_req | output | 1 | Memory write request |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid with mem_done |
| mem_done | input | 1 | Memory access complete |
| dsk_addr | output | 18 | Disk word address of the current word |
| dsk_in_valid | input | 1 | Disk has a word for memory |
| dsk_in_data | input | 12 | Word from disk |
| dsk_in_ready | output | 1 | Engine accepts a disk word |
| dsk_out_valid | output | 1 | Engine offers a word to disk |
| dsk_out_data | output | 12 | Word to disk |
| dsk_out_ready | input | 1 | Disk accepts the offered word |

## Verification
Transfers run in both directions, across both memory fields used by the bench, and for several lengths: one word, a handful of words, and the full 4096 words given by a zero count. A single word checks where the transfer ends, a zero count checks the 12-bit wrap, and several words check the per-word increments.

Every word read from the disk is a function of its disk address, and the memory is pre-filled with a function of its address. Each destination word therefore shows both the disk address and the buffer address it was tied to. The bench also checks the words just before and after the buffer, so writes outside the buffer are caught.

Buffer pointers near 7777 and disk addresses near 777777 expose any carry into the field or any loss of the wrap. Instructions issued in the middle of a transfer tell an ignored command apart from a field, direction or address that has been switched. Memory latency and disk-port stalls vary from cycle to cycle, which separates a correct handshake from one that relies on fixed timing.

// File: rtl/dbk_pkg.sv
package dbk_pkg;
    localparam int WORD_W  = 12;
    localparam int FIELD_W = 3;
    localparam int EXT_W   = 6;

    localparam logic [2:0] IOT_OPC   = 3'o6;
    localparam logic [5:0] DEV_XFER  = 6'o60;
    localparam logic [5:0] DEV_SETUP = 6'o61;
    localparam logic [5:0] DEV_EXT   = 6'o64;
    localparam logic [2:0] FN_SKIP   = 3'o1;
    localparam logic [2:0] FN_GO_RD  = 3'o3;
    localparam logic [2:0] FN_GO_WR  = 3'o5;
    localparam logic [2:0] FN_IE     = 3'o1;
    localparam logic [2:0] FN_FIELD  = 3'o5;
    localparam logic [2:0] FN_EXT    = 3'o3;

    localparam logic [WORD_W-1:0] CNT_LOC = 12'o7750;
    localparam logic [WORD_W-1:0] PTR_LOC = 12'o7751;

    typedef struct packed {
        logic ld_field;
        logic ld_ext;
        logic ld_ie;
        logic go_rd;
        logic go_wr;
        logic skip_hit;
    } cmd_t;

    typedef enum logic [3:0] {
        S_IDLE, S_CNT_RD, S_CNT_WR, S_PTR_RD, S_PTR_WR,
        S_DSK_IN, S_DAT_WR, S_DAT_RD, S_DSK_OUT
    } seq_e;
endpackage

// File: rtl/dbk_iot_decode.sv
module dbk_iot_decode
    import dbk_pkg::*;
#(
    parameter int INSN_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iot_valid,
    input  logic [1:0]        iot_phase,
    input  logic [INSN_W-1:0] iot_insn,
    output cmd_t              cmd
);
    localparam int DEV_LO = 3;
    localparam int DEV_HI = 8;

    typedef struct packed {
        logic [1:0] phase;
    } dec_s;

    dec_s q, d;
    logic       enter_ph1;
    logic       is_iot;
    logic [5:0] dev;
    logic [2:0] fn;

    always_comb begin
        d.phase   = iot_valid ? iot_phase : 2'd0;
        is_iot    = iot_valid && (iot_insn[INSN_W-1:INSN_W-3] == IOT_OPC);
        dev       = iot_insn[DEV_HI:DEV_LO];
        fn        = iot_insn[2:0];
        enter_ph1 = is_iot && (iot_phase == 2'd1) && (q.phase != 2'd1);
        cmd.go_rd    = enter_ph1 && dev == DEV_XFER  && fn == FN_GO_RD;
        cmd.go_wr    = enter_ph1 && dev == DEV_XFER  && fn == FN_GO_WR;
        cmd.ld_field = enter_ph1 && dev == DEV_SETUP && fn == FN_FIELD;
        cmd.ld_ie    = enter_ph1 && dev == DEV_SETUP && fn == FN_IE;
        cmd.ld_ext   = enter_ph1 && dev == DEV_EXT   && fn == FN_EXT;
        cmd.skip_hit = is_iot && dev == DEV_XFER && fn == FN_SKIP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: an instruction acts only once even if phase 1 lasts longer
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.go_rd || cmd.go_wr || cmd.ld_field || cmd.ld_ext || cmd.ld_ie)
        |=> !(cmd.go_rd || cmd.go_wr || cmd.ld_field || cmd.ld_ext || cmd.ld_ie));
endmodule

// File: rtl/dbk_xfer_seq.sv
module dbk_xfer_seq
    import dbk_pkg::*;
#(
    parameter int                DW      = WORD_W,
    parameter int                FW      = FIELD_W,
    parameter int                XW      = EXT_W,
    parameter logic [DW-1:0]     CNT_AT  = CNT_LOC,
    parameter logic [DW-1:0]     PTR_AT  = PTR_LOC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             cmd,
    input  logic [DW-1:0]    iot_wdata,
    output logic             busy,
    output logic             flag,
    output logic             ie,
    output logic             mem_rd_req,
    output logic             mem_wr_req,
    output logic [FW+DW-1:0] mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_done,
    output logic [XW+DW-1:0] dsk_addr,
    input  logic             dsk_in_valid,
    input  logic [DW-1:0]    dsk_in_data,
    output logic             dsk_in_ready,
    output logic             dsk_out_valid,
    output logic [DW-1:0]    dsk_out_data,
    input  logic             dsk_out_ready
);
    localparam int DAW = XW + DW;

    typedef struct packed {
        seq_e           st;
        logic [DW-1:0]  cnt;
        logic [DW-1:0]  ptr;
        logic [DW-1:0]  word;
        logic [FW-1:0]  field;
        logic [DAW-1:0] daddr;
        logic           ie;
        logic           flag;
        logic           to_mem;
    } seq_s;

    seq_s q, d;
    logic word_end;

    always_comb begin
        d        = q;
        word_end = 1'b0;
        if (cmd.ld_ie) d.ie = iot_wdata[0];
        case (q.st)
            S_IDLE: begin
                if (cmd.ld_field) d.field = iot_wdata[FW+2:3];
                if (cmd.ld_ext)   d.daddr[DAW-1:DW] = iot_wdata[XW-1:0];
                if (cmd.go_rd || cmd.go_wr) begin
                    d.daddr[DW-1:0] = iot_wdata;
                    d.to_mem        = cmd.go_rd;
                    d.flag          = 1'b0;
                    d.st            = S_CNT_RD;
                end
            end
            S_CNT_RD: if (mem_done) begin
                d.cnt = mem_rdata + 1'b1;
                d.st  = S_CNT_WR;
            end
            S_CNT_WR: if (mem_done) d.st = S_PTR_RD;
            S_PTR_RD: if (mem_done) begin
                d.ptr = mem_rdata + 1'b1;
                d.st  = S_PTR_WR;
            end
            S_PTR_WR: if (mem_done) d.st = q.to_mem ? S_DSK_IN : S_DAT_RD;
            S_DSK_IN: if (dsk_in_valid) begin
                d.word = dsk_in_data;
                d.st   = S_DAT_WR;
            end
            S_DAT_WR: if (mem_done) word_end = 1'b1;
            S_DAT_RD: if (mem_done) begin
                d.word = mem_rdata;
                d.st   = S_DSK_OUT;
            end
            S_DSK_OUT: if (dsk_out_ready) word_end = 1'b1;
            default: d.st = S_IDLE;
        endcase
        if (word_end) begin
            d.daddr = q.daddr + 1'b1;
            if (q.cnt == '0) begin
                d.st   = S_IDLE;
                d.flag = 1'b1;
            end else begin
                d.st   = S_CNT_RD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    always_comb begin
        mem_rd_req = 1'b0;
        mem_wr_req = 1'b0;
        mem_addr   = {{FW{1'b0}}, CNT_AT};
        mem_wdata  = q.cnt;
        case (q.st)
            S_CNT_RD: mem_rd_req = 1'b1;
            S_CNT_WR: mem_wr_req = 1'b1;
            S_PTR_RD: begin
                mem_rd_req = 1'b1;
                mem_addr   = {{FW{1'b0}}, PTR_AT};
            end
            S_PTR_WR: begin
                mem_wr_req = 1'b1;
                mem_addr   = {{FW{1'b0}}, PTR_AT};
                mem_wdata  = q.ptr;
            end
            S_DAT_RD: begin
                mem_rd_req = 1'b1;
                mem_addr   = {q.field, q.ptr};
            end
            S_DAT_WR: begin
                mem_wr_req = 1'b1;
                mem_addr   = {q.field, q.ptr};
                mem_wdata  = q.word;
            end
            default: ;
        endcase
    end

    assign busy          = (q.st != S_IDLE);
    assign flag          = q.flag;
    assign ie            = q.ie;
    assign dsk_addr      = q.daddr;
    assign dsk_in_ready  = (q.st == S_DSK_IN);
    assign dsk_out_valid = (q.st == S_DSK_OUT);
    assign dsk_out_data  = q.word;

    // R13: requests and their address and data hold until done
    a_r13_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_done) |=> (mem_rd_req && $stable(mem_addr)));
    a_r13_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_done) |=> (mem_wr_req && $stable(mem_addr) && $stable(mem_wdata)));
    // R8: offered disk word held until accepted
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_out_valid && !dsk_out_ready) |=> (dsk_out_valid && $stable(dsk_out_data) && $stable(dsk_addr)));
    // R6: disk address advances by one per accepted outgoing word
    a_r6_daddr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_out_valid && dsk_out_ready) |=> (dsk_addr == $past(dsk_addr) + 1'b1));
    // R9: flag low whenever a transfer runs; start enters busy with flag clear
    a_r9_flag_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !flag);
    a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd.go_rd || cmd.go_wr) && !busy) |=> (busy && !flag));
    // R11: a field load during a transfer leaves the field alone
    a_r11_field_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd.ld_field) |=> (q.field == $past(q.field)));
endmodule

// File: rtl/dbk_disk_dma.sv
module dbk_disk_dma
    import dbk_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int FW = FIELD_W,
    parameter int XW = EXT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iot_valid,
    input  logic [1:0]       iot_phase,
    input  logic [DW-1:0]    iot_insn,
    input  logic [DW-1:0]    iot_wdata,
    output logic             iot_skip,
    output logic             irq,
    output logic             xfer_done,
    output logic             mem_rd_req,
    output logic             mem_wr_req,
    output logic [FW+DW-1:0] mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_done,
    output logic [XW+DW-1:0] dsk_addr,
    input  logic             dsk_in_valid,
    input  logic [DW-1:0]    dsk_in_data,
    output logic             dsk_in_ready,
    output logic             dsk_out_valid,
    output logic [DW-1:0]    dsk_out_data,
    input  logic             dsk_out_ready
);
    cmd_t cmd;
    logic busy, flag, ie;

    dbk_iot_decode #(.INSN_W(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid),
        .iot_phase(iot_phase), .iot_insn(iot_insn), .cmd(cmd)
    );

    dbk_xfer_seq #(.DW(DW), .FW(FW), .XW(XW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .iot_wdata(iot_wdata),
        .busy(busy), .flag(flag), .ie(ie),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_done(mem_done),
        .dsk_addr(dsk_addr), .dsk_in_valid(dsk_in_valid),
        .dsk_in_data(dsk_in_data), .dsk_in_ready(dsk_in_ready),
        .dsk_out_valid(dsk_out_valid), .dsk_out_data(dsk_out_data),
        .dsk_out_ready(dsk_out_ready)
    );

    assign xfer_done = flag;
    assign irq       = flag && ie;
    assign iot_skip  = cmd.skip_hit && flag;

    // R10: an interrupt never appears without a raised done flag
    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> xfer_done);
    // R1/R3: never a read and a write at once
    a_r3_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));
endmodule

// File: tb/dbk_disk_dma_tb_top.sv
`timescale 1ns/1ps
module dbk_disk_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iot_valid = 1'b0;
    logic [1:0]  iot_phase = 2'd0;
    logic [11:0] iot_insn = '0, iot_wdata = '0;
    logic        iot_skip, irq, xfer_done;
    logic        mem_rd_req, mem_wr_req;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata, mem_rdata;
    logic        mem_done;
    logic [17:0] dsk_addr;
    logic        dsk_in_valid, dsk_in_ready, dsk_out_valid, dsk_out_ready;
    logic [11:0] dsk_in_data, dsk_out_data;

    always #2 clk = ~clk;

    dbk_disk_dma dut_i (
        .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_phase(iot_phase),
        .iot_insn(iot_insn), .iot_wdata(iot_wdata), .iot_skip(iot_skip),
        .irq(irq), .xfer_done(xfer_done), .mem_rd_req(mem_rd_req),
        .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_done(mem_done), .dsk_addr(dsk_addr),
        .dsk_in_valid(dsk_in_valid), .dsk_in_data(dsk_in_data),
        .dsk_in_ready(dsk_in_ready), .dsk_out_valid(dsk_out_valid),
        .dsk_out_data(dsk_out_data), .dsk_out_ready(dsk_out_ready)
    );

    int checks = 0, fails = 0, cyc = 0;

    function automatic logic [11:0] dfn(input logic [17:0] a);
        return a[11:0] ^ {a[17:12], a[17:12]} ^ 12'o5252;
    endfunction
    function automatic logic [11:0] mfn(input logic [12:0] i);
        return (i[11:0] * 12'd5) + {10'd0, i[12], 1'b1};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
        end
    endtask

    // memory model: 8K words, latency varies with the cycle count
    logic [11:0] mem [0:8191];
    logic        done_r = 1'b0;
    logic [11:0] rdat_r = '0;
    int          wait_c = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done_r) done_r <= 1'b0;
        else if (mem_rd_req || mem_wr_req) begin
            if (wait_c > 0) wait_c <= wait_c - 1;
            else begin
                done_r <= 1'b1;
                rdat_r <= mem[mem_addr[12:0]];
                if (mem_wr_req) mem[mem_addr[12:0]] <= mem_wdata;
                wait_c <= (cyc % 3 == 0) ? 2 : 0;
            end
        end
    end
    assign mem_done      = done_r;
    assign mem_rdata     = rdat_r;
    assign dsk_in_valid  = (cyc % 4) != 1;
    assign dsk_out_ready = (cyc % 5) != 2;
    assign dsk_in_data   = dfn(dsk_addr);

    // monitors
    int          acc_n = 0, in_n = 0, out_n = 0, bad_field = 0;
    logic [2:0]  exp_field = '0;
    logic [15:0] acc_log [0:4];
    logic [11:0] out_d [0:63];
    logic [17:0] out_a [0:63];
    always @(posedge clk) if (rst_n) begin
        if (mem_done && (mem_rd_req || mem_wr_req)) begin
            if (acc_n < 5) acc_log[acc_n] = {mem_wr_req, mem_addr};
            acc_n++;
            if (mem_addr != 15'o07750 && mem_addr != 15'o07751 && mem_addr[14:12] != exp_field)
                bad_field++;
        end
        if (dsk_in_valid && dsk_in_ready) in_n++;
        if (dsk_out_valid && dsk_out_ready) begin
            if (out_n < 64) begin
                out_d[out_n] = dsk_out_data;
                out_a[out_n] = dsk_addr;
            end
            out_n++;
        end
    end

    always @(posedge clk) if (cyc > 190000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic iot(input logic [11:0] insn, input logic [11:0] data);
        @(negedge clk); iot_valid = 1'b1; iot_insn = insn; iot_wdata = data; iot_phase = 2'd0;
        @(negedge clk); iot_phase = 2'd1;
        @(negedge clk); iot_phase = 2'd2;
        @(negedge clk); iot_phase = 2'd3;
        @(negedge clk); iot_valid = 1'b0; iot_phase = 2'd0;
    endtask

    task automatic probe_skip(output logic s);
        @(negedge clk); iot_valid = 1'b1; iot_insn = 12'o6601; iot_wdata = '0; iot_phase = 2'd0;
        @(negedge clk); iot_phase = 2'd1;
        @(negedge clk); iot_phase = 2'd2;
        @(negedge clk); s = iot_skip; iot_phase = 2'd3;
        @(negedge clk); iot_valid = 1'b0; iot_phase = 2'd0;
    endtask

    task automatic setup(input int n, input logic [11:0] ma, input logic [2:0] fld);
        mem[13'o7750] = 12'(-n);
        mem[13'o7751] = ma - 12'd1;
        acc_n = 0; in_n = 0; out_n = 0; bad_field = 0; exp_field = fld;
    endtask

    task automatic start(input logic to_mem, input logic [2:0] fld, input logic [17:0] da);
        iot(12'o6615, {6'd0, fld, 3'd0});
        iot(12'o6643, {6'd0, da[17:12]});
        iot(to_mem ? 12'o6603 : 12'o6605, da[11:0]);
    endtask

    task automatic wait_done(input string tag, input int limit);
        int n = 0;
        while (!xfer_done && n < limit) begin @(negedge clk); n++; end
        chk(tag, {31'd0, xfer_done}, 32'd1);
    endtask

    task automatic check_to_mem(input string tag, input logic [2:0] fld, input logic [11:0] ma,
                                input logic [17:0] da, input int n);
        int errs = 0;
        for (int i = 0; i < n; i++) begin
            logic [11:0] p = ma + 12'(i);
            if (mem[{fld[0], p}] !== dfn(da + 18'(i))) errs++;
        end
        chk(tag, errs, 0);
    endtask

    logic s;
    initial begin
        for (int i = 0; i < 8192; i++) mem[i] = mfn(13'(i));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flag", {31'd0, xfer_done}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 reqs", {30'd0, mem_rd_req, mem_wr_req}, 0);
        chk("R1 disk port", {30'd0, dsk_in_ready, dsk_out_valid}, 0);
        probe_skip(s);
        chk("R1 skip", {31'd0, s}, 0);

        // T1: disk to memory, field 1, 5 words, interrupts on (R2 R3 R4 R7 R9 R10)
        iot(12'o6611, 12'd1);
        setup(5, 12'o0100, 3'd1);
        start(1'b1, 3'd1, 18'o012345);
        chk("R9 flag low after start", {31'd0, xfer_done}, 0);
        probe_skip(s);
        chk("R9 no skip while busy", {31'd0, s}, 0);
        wait_done("R9 done T1", 20000);
        check_to_mem("R7 data T1", 3'd1, 12'o0100, 18'o012345, 5);
        chk("R5 below buffer", mem[13'o10077], mfn(13'o10077));
        chk("R5 above buffer", mem[13'o10105], mfn(13'o10105));
        chk("R4 count loc", mem[13'o7750], 0);
        chk("R5 ptr loc", mem[13'o7751], 12'o0104);
        chk("R3 access count", acc_n, 25);
        chk("R3 acc0", acc_log[0], {1'b0, 15'o07750});
        chk("R3 acc1", acc_log[1], {1'b1, 15'o07750});
        chk("R3 acc2", acc_log[2], {1'b0, 15'o07751});
        chk("R3 acc3", acc_log[3], {1'b1, 15'o07751});
        chk("R3 acc4", acc_log[4], {1'b1, 15'o10100});
        chk("R7 words in", in_n, 5);
        chk("R6 daddr after", dsk_addr, 18'o012352);
        chk("R10 irq on", {31'd0, irq}, 1);
        probe_skip(s);
        chk("R9 skip when done", {31'd0, s}, 1);
        iot(12'o6611, 12'd0);
        @(negedge clk);
        chk("R10 irq off with ie clear", {31'd0, irq}, 0);

        // T2: memory to disk, field 0, 7 words (R8 R6)
        setup(7, 12'o0200, 3'd0);
        start(1'b0, 3'd0, 18'o000010);
        wait_done("R9 done T2", 20000);
        chk("R8 words out", out_n, 7);
        chk("R8 no words in", in_n, 0);
        chk("R3 data read", acc_log[4], {1'b0, 15'o00200});
        for (int i = 0; i < 7; i++) begin
            chk("R8 out data", out_d[i], mfn(13'(12'o0200 + i)));
            chk("R6 out addr", out_a[i], 18'o000010 + 18'(i));
        end
        chk("R3 field", bad_field, 0);

        // T3: pointer and disk address wrap (R5 R6)
        setup(4, 12'o7776, 3'd1);
        start(1'b1, 3'd1, 18'o777776);
        wait_done("R9 done T3", 20000);
        check_to_mem("R5 R6 wrap data", 3'd1, 12'o7776, 18'o777776, 4);
        chk("R5 ptr wrap", mem[13'o7751], 12'o0001);
        chk("R5 field kept", bad_field, 0);
        chk("R5 field 0 untouched", mem[13'o0000], mfn(13'o0000));
        chk("R6 daddr wrap", dsk_addr, 18'o000002);

        // T4: commands during a transfer ignored (R11)
        setup(6, 12'o0300, 3'd1);
        start(1'b1, 3'd1, 18'o004000);
        iot(12'o6615, 12'o0000);
        iot(12'o6643, 12'o0033);
        iot(12'o6605, 12'o1234);
        wait_done("R9 done T4", 20000);
        chk("R11 words in", in_n, 6);
        chk("R11 no words out", out_n, 0);
        chk("R11 field", bad_field, 0);
        check_to_mem("R11 data", 3'd1, 12'o0300, 18'o004000, 6);
        chk("R11 daddr", dsk_addr, 18'o004006);

        // T5: single word (R4)
        setup(1, 12'o0400, 3'd0);
        start(1'b1, 3'd0, 18'o000100);
        wait_done("R9 done T5", 20000);
        chk("R4 one word", in_n, 1);
        chk("R4 five accesses", acc_n, 5);
        chk("R4 data", mem[13'o0400], dfn(18'o000100));
        chk("R4 next untouched", mem[13'o0401], mfn(13'o0401));

        // T6: zero count moves 4096 words (R12)
        setup(0, 12'o0000, 3'd1);
        start(1'b1, 3'd1, 18'o200000);
        wait_done("R12 done", 150000);
        chk("R12 words", in_n, 4096);
        chk("R12 accesses", acc_n, 5 * 4096);
        chk("R12 count loc", mem[13'o7750], 0);
        chk("R12 ptr loc", mem[13'o7751], 12'o7777);
        check_to_mem("R12 data", 3'd1, 12'o0000, 18'o200000, 4096);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule